// File: doc/BRIEF.md
# 16-bit Bit Scan and Count Unit

This unit computes the bit-scan and bit-count results of a processor datapath. Each operation takes one 16-bit source operand: a forward scan for the lowest set bit, a reverse scan for the highest set bit, a population count, a trailing-zero count and a leading-zero count. With the result, the unit produces a destination write-enable and a new value plus an update mask for each of the six arithmetic flags. The flag pipeline merges only the masked flags into its state.

The caller presents an opcode, the source operand and the current destination value together with a valid strobe. All of the arithmetic is combinational. One register stage then holds the outcome, so the outcome appears on the clock edge after the strobe, with an output-valid pulse. The scans and the counts treat a zero source differently. A scan of zero leaves the destination alone and only raises the zero flag. A count always writes, and a zero source yields the full width, 16.

Top module: `bscan_unit`

## Requirements
- R1: The outputs are registered. `out_valid` is high in the cycle after each cycle with `in_valid` high, and low otherwise. While `rst_n` is low, `out_valid`, `dst_we`, `res_val`, `flag_val` and `flag_mask` are all zero.
- R2: Opcode 0 (forward scan) with a nonzero source writes (`dst_we`=1) the index of the lowest set bit of the source.
- R3: Opcode 1 (reverse scan) with a nonzero source writes the index of the highest set bit of the source.
- R4: Flag vectors use bit 0=CF, 1=PF, 2=AF, 3=ZF, 4=SF, 5=OF. For a scan (opcode 0 or 1) of a nonzero source, all six mask bits are set. OF, CF, AF and ZF are 0, SF is bit 15 of the result, and PF is 1 exactly when bits 7..0 of the result hold an even number of ones.
- R5: A scan (opcode 0 or 1) of a zero source does not write (`dst_we`=0), and `res_val` returns the destination value it was given. Only the ZF mask bit is set, and the ZF value is 1.
- R6: Opcode 2 (population count) writes the number of set bits in the source. All six mask bits are set, ZF is 1 only when the count is zero, and every other flag value is 0.
- R7: Opcode 3 (trailing-zero count) always writes the number of zero bits below the lowest set bit, or 16 for a zero source.
- R8: Opcode 4 (leading-zero count) always writes the number of zero bits above the highest set bit, or 16 for a zero source.
- R9: For opcodes 3 and 4, only the CF and ZF mask bits are set. CF is 1 exactly when the source is zero, and ZF is 1 exactly when the result is zero.
- R10: Opcodes 5, 6 and 7 still produce an `out_valid` pulse, but they do not write, and both flag vectors are zero. `res_val` returns the destination value.
- R11: In a cycle where `out_valid` is low, `dst_we` and `flag_mask` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 3 | Operation code (0..4 used) |
| src_val | input | 16 | Source operand |
| dst_val | input | 16 | Current destination value |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| res_val | output | 16 | Result value |
| dst_we | output | 1 | Destination write-enable |
| flag_val | output | 6 | New flag values (CF, PF, AF, ZF, SF, OF from bit 0) |
| flag_mask | output | 6 | Per-flag update enables, same bit order |

## Verification
The bench aims at the zero-source boundary, where the operations split apart:
- A scan that wrongly writes on a zero source corrupts the destination. The bench checks `res_val` against the destination value it supplied and checks that `dst_we` stays low.
- A count that forgets the width case returns 0 or 15 instead of 16, and also sets ZF where CF belongs.

The single-bit sources at both ends (bit 0 and bit 15) catch off-by-one index errors and swapped scan directions. Scan results with odd and even ones in the low byte expose a parity taken from the wrong bits or with the wrong polarity. Reserved opcodes, back-to-back strobes and idle gaps between them show whether writes or flag masks leak out without a valid result.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  // operation codes
  localparam logic [2:0] OP_FWD = 3'd0;
  localparam logic [2:0] OP_REV = 3'd1;
  localparam logic [2:0] OP_POP = 3'd2;
  localparam logic [2:0] OP_TZC = 3'd3;
  localparam logic [2:0] OP_LZC = 3'd4;

  // flag bit positions inside flag_val / flag_mask
  localparam int FLG_CF = 0;
  localparam int FLG_PF = 1;
  localparam int FLG_AF = 2;
  localparam int FLG_ZF = 3;
  localparam int FLG_SF = 4;
  localparam int FLG_OF = 5;
  localparam int FLG_N  = 6;
endpackage

// File: rtl/bscan_count.sv
module bscan_count #(
  parameter int W = 16
) (
  input  logic [W-1:0] src,
  output logic         src_zero,
  output logic [W-1:0] low_idx,
  output logic [W-1:0] high_idx,
  output logic [W-1:0] pop_cnt,
  output logic [W-1:0] tz_cnt,
  output logic [W-1:0] lz_cnt
);
  // index of the lowest set bit, 0 when none
  function automatic logic [W-1:0] find_low(input logic [W-1:0] v);
    logic [W-1:0] r;
    r = '0;
    for (int i = W - 1; i >= 0; i--)
      if (v[i]) r = W'(i);
    return r;
  endfunction

  // index of the highest set bit, 0 when none
  function automatic logic [W-1:0] find_high(input logic [W-1:0] v);
    logic [W-1:0] r;
    r = '0;
    for (int i = 0; i < W; i++)
      if (v[i]) r = W'(i);
    return r;
  endfunction

  function automatic logic [W-1:0] ones_total(input logic [W-1:0] v);
    logic [W-1:0] r;
    r = '0;
    for (int i = 0; i < W; i++)
      r = r + W'(v[i]);
    return r;
  endfunction

  localparam logic [W-1:0] FULL = W'(W);
  localparam logic [W-1:0] TOP  = W'(W - 1);

  assign src_zero = (src == '0);
  assign low_idx  = find_low(src);
  assign high_idx = find_high(src);
  assign pop_cnt  = ones_total(src);
  assign tz_cnt   = src_zero ? FULL : low_idx;
  assign lz_cnt   = src_zero ? FULL : (TOP - high_idx);
endmodule

// File: rtl/bscan_flags.sv
module bscan_flags
  import bscan_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]       op,
  input  logic             src_zero,
  input  logic [W-1:0]     res,
  output logic [FLG_N-1:0] fval,
  output logic [FLG_N-1:0] fmask,
  output logic             we_ok
);
  // even parity of the low byte: 1 when the count of ones is even
  function automatic logic low_byte_even(input logic [W-1:0] v);
    return ~^v[7:0];
  endfunction

  always_comb begin
    fval  = '0;
    fmask = '0;
    we_ok = 1'b0;
    case (op)
      OP_FWD, OP_REV: begin
        if (src_zero) begin
          fmask[FLG_ZF] = 1'b1;
          fval[FLG_ZF]  = 1'b1;
        end else begin
          fmask        = '1;
          fval[FLG_SF] = res[W-1];
          fval[FLG_PF] = low_byte_even(res);
          we_ok        = 1'b1;
        end
      end
      OP_POP: begin
        fmask        = '1;
        fval[FLG_ZF] = (res == '0);
        we_ok        = 1'b1;
      end
      OP_TZC, OP_LZC: begin
        fmask[FLG_CF] = 1'b1;
        fmask[FLG_ZF] = 1'b1;
        fval[FLG_CF]  = src_zero;
        fval[FLG_ZF]  = (res == '0);
        we_ok         = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bscan_unit.sv
module bscan_unit
  import bscan_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [2:0]       op_sel,
  input  logic [W-1:0]     src_val,
  input  logic [W-1:0]     dst_val,
  output logic             out_valid,
  output logic [W-1:0]     res_val,
  output logic             dst_we,
  output logic [FLG_N-1:0] flag_val,
  output logic [FLG_N-1:0] flag_mask
);
  logic             src_zero;
  logic [W-1:0]     low_idx, high_idx, pop_cnt, tz_cnt, lz_cnt;
  logic [W-1:0]     calc_res;
  logic [FLG_N-1:0] calc_fval, calc_fmask;
  logic             calc_we;

  bscan_count #(.W(W)) u_cnt (
    .src      (src_val),
    .src_zero (src_zero),
    .low_idx  (low_idx),
    .high_idx (high_idx),
    .pop_cnt  (pop_cnt),
    .tz_cnt   (tz_cnt),
    .lz_cnt   (lz_cnt)
  );

  // result selection; scans of zero and reserved codes echo the destination
  always_comb begin
    case (op_sel)
      OP_FWD:  calc_res = src_zero ? dst_val : low_idx;
      OP_REV:  calc_res = src_zero ? dst_val : high_idx;
      OP_POP:  calc_res = pop_cnt;
      OP_TZC:  calc_res = tz_cnt;
      OP_LZC:  calc_res = lz_cnt;
      default: calc_res = dst_val;
    endcase
  end

  bscan_flags #(.W(W)) u_flg (
    .op       (op_sel),
    .src_zero (src_zero),
    .res      (calc_res),
    .fval     (calc_fval),
    .fmask    (calc_fmask),
    .we_ok    (calc_we)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_val   <= '0;
      dst_we    <= 1'b0;
      flag_val  <= '0;
      flag_mask <= '0;
    end else begin
      out_valid <= in_valid;
      dst_we    <= in_valid & calc_we;
      flag_mask <= in_valid ? calc_fmask : '0;
      if (in_valid) begin
        res_val  <= calc_res;
        flag_val <= calc_fval;
      end
    end
  end

  // named events for the checks below
  logic scan_op, cnt_op;
  assign scan_op = (op_sel == OP_FWD) || (op_sel == OP_REV);
  assign cnt_op  = (op_sel == OP_TZC) || (op_sel == OP_LZC);

  // R1
  out_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!dst_we && flag_mask == '0));

  // R5
  scan_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && scan_op && src_val == '0) |=>
      (!dst_we && res_val == $past(dst_val) && $onehot0(flag_mask) && flag_mask[FLG_ZF] && flag_val[FLG_ZF]));

  // R2
  fwd_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_FWD && src_val != '0) |=>
      (dst_we && ((($past(src_val) >> res_val) & W'(1)) == W'(1))
              && (($past(src_val) & ((W'(1) << res_val) - W'(1))) == '0)));

  // R6
  pop_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == OP_POP) |=>
      (dst_we && res_val == W'($countones($past(src_val))) && flag_mask == '1));

  // R9
  cnt_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cnt_op) |=>
      (dst_we && $countones(flag_mask) == 2 && flag_val[FLG_CF] == ($past(src_val) == '0)));

  // R4
  scan_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && scan_op && src_val != '0) |=>
      (flag_mask == '1 && !flag_val[FLG_ZF] && !flag_val[FLG_CF] && !flag_val[FLG_OF]));
endmodule

// File: tb/bscan_unit_tb.sv
module bscan_unit_tb;
  localparam int W = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [2:0]    op_sel = '0;
  logic [W-1:0]  src_val = '0;
  logic [W-1:0]  dst_val = '0;
  logic          out_valid;
  logic [W-1:0]  res_val;
  logic          dst_we;
  logic [5:0]    flag_val;
  logic [5:0]    flag_mask;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bscan_unit #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .src_val(src_val), .dst_val(dst_val), .out_valid(out_valid),
    .res_val(res_val), .dst_we(dst_we), .flag_val(flag_val), .flag_mask(flag_mask)
  );

  typedef struct {
    logic [W-1:0] res;
    logic         we;
    logic [5:0]   fv;
    logic [5:0]   fm;
    string        rtag;
    string        ftag;
  } exp_t;

  exp_t sb[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // independent reference model
  function automatic exp_t model(input logic [2:0] op, input logic [W-1:0] s,
                                 input logic [W-1:0] d);
    exp_t e;
    int lo = -1, hi = -1, n = 0;
    int k;
    k = 0;
    while (k < W) begin
      if (s[k]) begin
        if (lo < 0) lo = k;
        hi = k;
        n++;
      end
      k++;
    end
    e.res = d; e.we = 1'b0; e.fv = '0; e.fm = '0; e.rtag = "R10"; e.ftag = "R10";
    case (op)
      3'd0, 3'd1: begin
        if (s == 0) begin
          e.rtag = "R5"; e.ftag = "R5";
          e.fm = 6'b001000; e.fv = 6'b001000;
        end else begin
          e.rtag = (op == 3'd0) ? "R2" : "R3";
          e.ftag = "R4";
          e.res = (op == 3'd0) ? W'(lo) : W'(hi);
          e.we = 1'b1;
          e.fm = 6'b111111;
          e.fv[4] = e.res[W-1];
          e.fv[1] = ($countones(e.res[7:0]) % 2) == 0;
        end
      end
      3'd2: begin
        e.rtag = "R6"; e.ftag = "R6";
        e.res = W'(n); e.we = 1'b1; e.fm = 6'b111111; e.fv[3] = (n == 0);
      end
      3'd3, 3'd4: begin
        e.rtag = (op == 3'd3) ? "R7" : "R8";
        e.ftag = "R9";
        if (s == 0) e.res = W'(W);
        else e.res = (op == 3'd3) ? W'(lo) : W'(W - 1 - hi);
        e.we = 1'b1;
        e.fm = 6'b001001;
        e.fv[0] = (s == 0);
        e.fv[3] = (e.res == 0);
      end
      default: ;
    endcase
    return e;
  endfunction

  task automatic drive(input logic [2:0] op, input logic [W-1:0] s, input logic [W-1:0] d);
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; src_val = s; dst_val = d;
    sb.push_back(model(op, s, d));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      src_val = 16'hDEAD;
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n) begin
        if (out_valid) begin
          if (sb.size() == 0) begin
            check(1'b0, "R1", "unexpected out_valid", 1, 0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check(res_val == e.res, e.rtag, "result", res_val, e.res);
            check(dst_we == e.we, e.rtag, "write enable", W'(dst_we), W'(e.we));
            check(flag_mask == e.fm, e.ftag, "flag mask", W'(flag_mask), W'(e.fm));
            check(flag_val == e.fv, e.ftag, "flag values", W'(flag_val), W'(e.fv));
          end
        end else begin
          // R11: quiet when no result is presented
          check(!dst_we && flag_mask == 0, "R11", "idle write/mask",
                W'({dst_we, flag_mask}), 0);
          if (sb.size() != 0)
            check(1'b0, "R1", "missing out_valid", 0, 1);
        end
      end
    end
  end

  // watchdog
  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with a strobe held during reset
    in_valid = 1'b1; op_sel = 3'd2; src_val = 16'hFFFF; dst_val = 16'h1234;
    repeat (3) @(posedge clk);
    #2;
    check(!out_valid && !dst_we && res_val == 0 && flag_val == 0 && flag_mask == 0,
          "R1", "reset outputs", res_val, 0);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b1;
    idle(2);

    // R2 forward scan
    drive(3'd0, 16'h0001, 16'h1234);
    drive(3'd0, 16'h8000, 16'h1234);
    drive(3'd0, 16'h0A00, 16'h1234);
    drive(3'd0, 16'h0000, 16'h1234);   // R5
    idle(1);
    // R3 reverse scan
    drive(3'd1, 16'h8001, 16'hBEEF);
    drive(3'd1, 16'h0001, 16'hBEEF);
    drive(3'd1, 16'h00F0, 16'hBEEF);
    drive(3'd1, 16'h0000, 16'hBEEF);   // R5
    idle(2);
    // R6 population count
    drive(3'd2, 16'h0000, 16'h5A5A);
    drive(3'd2, 16'hFFFF, 16'h5A5A);
    drive(3'd2, 16'h5555, 16'h5A5A);
    drive(3'd2, 16'h8421, 16'h5A5A);
    idle(1);
    // R7 trailing zeros
    drive(3'd3, 16'h0000, 16'h7777);
    drive(3'd3, 16'h8000, 16'h7777);
    drive(3'd3, 16'h0001, 16'h7777);
    drive(3'd3, 16'h0010, 16'h7777);
    // R8 leading zeros
    drive(3'd4, 16'h0000, 16'h7777);
    drive(3'd4, 16'h0001, 16'h7777);
    drive(3'd4, 16'h8000, 16'h7777);
    drive(3'd4, 16'h00FF, 16'h7777);
    idle(1);
    // R10 reserved codes
    drive(3'd5, 16'h1234, 16'hCAFE);
    drive(3'd7, 16'h0000, 16'hF00D);
    idle(2);
    // mixed traffic with gaps
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] s;
      s = W'($urandom);
      if ((i % 7) == 0) s = '0;
      if ((i % 11) == 0) s = W'(1) << (i % W);
      drive(3'($urandom_range(0, 7)), s, W'($urandom));
      if ((i % 5) == 0) idle(1);
    end
    idle(4);
    check(sb.size() == 0, "R1", "drained", W'(sb.size()), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule